// File: doc/BRIEF.md
# Radar Result Stream Scheduler

This block decides which processed radar results are written into a host-side FIFO, and in what order. The radar pipeline produces three kinds of result record: range, Doppler and detection. Each kind arrives with its own single-cycle valid pulse and data word. A 3-bit stream-enable register, written by the host through a configuration strobe, selects which kinds are forwarded.

Doppler and detection results can arrive at any time. Each one is held in a data register with a sticky pending flag. Only a range-valid pulse starts a write burst. The burst writes the range record and then appends the pending Doppler and detection records of the enabled streams. The scheduler therefore never waits on a stream that may never produce data, and it cannot lock up at startup.

The FIFO side is a write strobe with a full flag for backpressure. A 2-bit kind code is sent beside each data word so the host can tell the records apart.

Top module: `result_stream_sched`

## Requirements
- R1: After reset the stream-enable register is 3'b001 (bit 0 range, bit 1 Doppler, bit 2 detection), so only range records are sent, and `fifo_wr` is low.
- R2: A cycle with `cfg_we` high loads `cfg_data` into the stream-enable register, and the next bursts follow the new value.
- R3: When idle, the scheduler starts a burst only on `range_valid`. Doppler or detection pulses alone never cause a FIFO write.
- R4: A burst writes in fixed order: the range record (kind 0), then the Doppler record (kind 1), then the detection record (kind 2). Each record carries the data word captured for it.
- R5: A `dopp_valid` pulse on an enabled Doppler stream sets a sticky pending flag. The flag stays set until its record is written in a later burst, and the record is sent once only.
- R6: A `det_valid` pulse on an enabled detection stream sets a sticky pending flag. The flag stays set until its record is written in a later burst, and the record is sent once only.
- R7: No write happens while `fifo_full` is high. The offered record is held and is written once the FIFO has room, so no record is lost.
- R8: If a new valid pulse arrives in the same cycle that its pending record is accepted, the flag stays set, and the new data is sent in the next burst.
- R9: The pending flag of a disabled stream is cleared and its record is not written. Re-enabling the stream later does not send the stale record.
- R10: When range records are disabled, a range-valid pulse still starts a burst. The range record is skipped and the pending enabled records are written.
- R11: A `range_valid` pulse that arrives while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Stream-enable register write strobe |
| cfg_data | input | 3 | New stream-enable value: bit 0 range, bit 1 Doppler, bit 2 detection |
| range_valid | input | 1 | Range result pulse; starts a burst |
| range_data | input | DW | Range result word |
| dopp_valid | input | 1 | Doppler result pulse |
| dopp_data | input | DW | Doppler result word |
| det_valid | input | 1 | Detection result pulse |
| det_data | input | DW | Detection result word |
| fifo_full | input | 1 | FIFO cannot accept a word this cycle |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_din | output | DW | Record data word to the FIFO |
| fifo_kind | output | 2 | Record kind: 0 range, 1 Doppler, 2 detection |

## Verification
Two events can meet in one clock cycle: the FIFO accepting a pending Doppler record, and a fresh Doppler pulse. The bench times a new `dopp_valid` pulse to the exact cycle in which the Doppler slot of a burst is written. It then checks that the burst carries the old word and that the next range-triggered burst carries the new word. A second meeting, a range pulse arriving during a burst held up by a full FIFO, is judged by counting the records after the stall ends.

// File: rtl/result_stream_sched.sv
module result_stream_sched #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_data,
  input  logic          range_valid,
  input  logic [DW-1:0] range_data,
  input  logic          dopp_valid,
  input  logic [DW-1:0] dopp_data,
  input  logic          det_valid,
  input  logic [DW-1:0] det_data,
  input  logic          fifo_full,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_din,
  output logic [1:0]    fifo_kind
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_RNG  = 2'd1;
  localparam logic [1:0] S_DOP  = 2'd2;
  localparam logic [1:0] S_DET  = 2'd3;
  localparam logic [2:0] EN_RST = 3'b001;

  logic [1:0]    st;
  logic [2:0]    en_q, en_nx;
  logic          pend_d, pend_t;
  logic [DW-1:0] rng_q, dop_q, det_q;
  logic          need_wr, step;

  assign en_nx   = cfg_we ? cfg_data : en_q;
  assign need_wr = (st == S_RNG && en_q[0]) ||
                   (st == S_DOP && en_q[1] && pend_d) ||
                   (st == S_DET && en_q[2] && pend_t);
  assign fifo_wr = need_wr && !fifo_full;
  assign step    = !need_wr || !fifo_full;

  always_comb begin
    case (st)
      S_DOP:   begin fifo_din = dop_q; fifo_kind = 2'd1; end
      S_DET:   begin fifo_din = det_q; fifo_kind = 2'd2; end
      default: begin fifo_din = rng_q; fifo_kind = 2'd0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      pend_d <= 1'b0;
      pend_t <= 1'b0;
    end else begin
      en_q   <= en_nx;
      pend_d <= ((pend_d && !(fifo_wr && st == S_DOP)) || dopp_valid) && en_nx[1];
      pend_t <= ((pend_t && !(fifo_wr && st == S_DET)) || det_valid) && en_nx[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dop_q <= '0;
      det_q <= '0;
    end else begin
      if (dopp_valid) dop_q <= dopp_data;
      if (det_valid)  det_q <= det_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      rng_q <= '0;
    end else if (st == S_IDLE) begin
      if (range_valid) begin
        st    <= S_RNG;
        rng_q <= range_data;
      end
    end else if (step) begin
      st <= (st == S_DET) ? S_IDLE : st + 2'd1;
    end
  end
endmodule

module result_stream_sched_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_data,
  input logic          range_valid,
  input logic          dopp_valid,
  input logic          det_valid,
  input logic          fifo_full,
  input logic          fifo_wr,
  input logic [DW-1:0] fifo_din,
  input logic [1:0]    fifo_kind,
  input logic [1:0]    st,
  input logic [2:0]    en_q,
  input logic          pend_d,
  input logic          pend_t,
  input logic          need_wr
);
  p_no_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (need_wr && fifo_full && !cfg_we) |=> (need_wr && $stable(fifo_kind)));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !fifo_wr);
  p_idle_stay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !range_valid) |=> (st == 2'd0));
  p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_kind != 2'd3));
  p_dop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dopp_valid && (cfg_we ? cfg_data[1] : en_q[1])) |=> pend_d);
  p_det_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && (cfg_we ? cfg_data[2] : en_q[2])) |=> pend_t);
  p_keep_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_kind == 2'd1 && dopp_valid && !cfg_we) |=> pend_d);
  p_drop_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] && !(cfg_we && cfg_data[1])) |=> !pend_d);
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !need_wr) |=> (st == 2'd0));
endmodule

bind result_stream_sched result_stream_sched_chk #(.DW(DW)) u_chk (.*);

// File: tb/result_stream_sched_test.sv
`timescale 1ns/1ps
module result_stream_sched_test;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_data = '0;
  logic range_valid = 1'b0, dopp_valid = 1'b0, det_valid = 1'b0;
  logic [DW-1:0] range_data = '0, dopp_data = '0, det_data = '0;
  logic fifo_full = 1'b0;
  logic fifo_wr;
  logic [DW-1:0] fifo_din;
  logic [1:0] fifo_kind;

  int checks = 0;
  int fails = 0;
  logic [1:0]    lk[$];
  logic [DW-1:0] ld[$];

  always #2 clk = ~clk;

  result_stream_sched #(.DW(DW)) uut (.*);

  always @(negedge clk) if (rst_n && fifo_wr) begin
    lk.push_back(fifo_kind);
    ld.push_back(fifo_din);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_en(logic [2:0] v);
    cfg_we = 1'b1; cfg_data = v; tick(); cfg_we = 1'b0;
  endtask
  task automatic p_rng(logic [DW-1:0] d);
    range_valid = 1'b1; range_data = d; tick(); range_valid = 1'b0;
  endtask
  task automatic p_dop(logic [DW-1:0] d);
    dopp_valid = 1'b1; dopp_data = d; tick(); dopp_valid = 1'b0;
  endtask
  task automatic p_det(logic [DW-1:0] d);
    det_valid = 1'b1; det_data = d; tick(); det_valid = 1'b0;
  endtask
  task automatic clr();
    lk.delete(); ld.delete();
  endtask
  task automatic rec(int i, string tag, int k, int d);
    if (lk.size() > i) begin
      chk(lk[i] == k, tag, lk[i], k);
      chk(ld[i] == d, tag, ld[i], d);
    end else chk(0, tag, lk.size(), i + 1);
  endtask

  task automatic t_reset();
    chk(fifo_wr == 1'b0, "R1 wr after reset", fifo_wr, 0);
    clr(); p_dop(16'h0D01); p_det(16'h0E01); p_rng(16'h0A01); tick(8);
    chk(lk.size() == 1, "R1 default only range", lk.size(), 1);
    rec(0, "R1 range record", 0, 16'h0A01);
  endtask

  task automatic t_idle_and_order();
    set_en(3'b111);
    clr(); p_dop(16'h0D02); p_det(16'h0E02); tick(8);
    chk(lk.size() == 0, "R3 no write without range", lk.size(), 0);
    p_rng(16'h0A02); tick(8);
    chk(lk.size() == 3, "R2 R4 burst size", lk.size(), 3);
    rec(0, "R4 range first", 0, 16'h0A02);
    rec(1, "R5 doppler second", 1, 16'h0D02);
    rec(2, "R6 detection third", 2, 16'h0E02);
    clr(); p_rng(16'h0A03); tick(8);
    chk(lk.size() == 1, "R5 R6 sent once", lk.size(), 1);
  endtask

  task automatic t_full();
    set_en(3'b001);
    clr(); fifo_full = 1'b1; p_rng(16'h0A04); tick(6);
    chk(lk.size() == 0, "R7 no write while full", lk.size(), 0);
    chk(fifo_din == 16'h0A04, "R7 word held", fifo_din, 16'h0A04);
    fifo_full = 1'b0; tick(6);
    chk(lk.size() == 1, "R7 released", lk.size(), 1);
    rec(0, "R7 record intact", 0, 16'h0A04);
  endtask

  task automatic t_same_cycle();
    set_en(3'b011);
    clr(); p_dop(16'h0D05); p_rng(16'h0A05); tick();
    p_dop(16'h0D06); tick(6);
    chk(lk.size() == 2, "R8 first burst size", lk.size(), 2);
    rec(1, "R8 old doppler word", 1, 16'h0D05);
    clr(); p_rng(16'h0A06); tick(8);
    chk(lk.size() == 2, "R8 flag kept", lk.size(), 2);
    rec(1, "R8 new doppler word", 1, 16'h0D06);
  endtask

  task automatic t_disable();
    set_en(3'b111);
    clr(); p_det(16'h0E07); set_en(3'b011); set_en(3'b111);
    p_rng(16'h0A07); tick(8);
    chk(lk.size() == 1, "R9 stale detection dropped", lk.size(), 1);
    rec(0, "R9 range only", 0, 16'h0A07);
  endtask

  task automatic t_range_off();
    set_en(3'b010);
    clr(); p_dop(16'h0D08); p_rng(16'h0A08); tick(8);
    chk(lk.size() == 1, "R10 range skipped", lk.size(), 1);
    rec(0, "R10 doppler sent", 1, 16'h0D08);
  endtask

  task automatic t_busy();
    set_en(3'b001);
    clr(); fifo_full = 1'b1; p_rng(16'h0A09); tick(2);
    p_rng(16'h0A0A); tick(2); fifo_full = 1'b0; tick(8);
    chk(lk.size() == 1, "R11 busy pulse ignored", lk.size(), 1);
    rec(0, "R11 first word kept", 0, 16'h0A09);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_idle_and_order();
    t_full();
    t_same_cycle();
    t_disable();
    t_range_off();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule